// File: doc/BRIEF.md
# Level-Masked Interrupt Acceptance Unit

This block gathers interrupt requests from a set of peripheral sources and decides when the processor takes one. Each source has two flags. A cause flag is set by a hardware event and cleared only by software. An enable flag is set and cleared by software. Each source also carries a 3-bit priority level. A source whose flags are both set, and whose level is not the "off" code, places a request. Among the requests present in a cycle, one winner is chosen, and its level goes to the acceptance logic.

The acceptance logic holds the processor's current level mask and a global interrupt-enable flag. A request is taken only when all of these hold:
- its level is strictly more urgent than the mask,
- the global flag is set,
- the processor reports an instruction boundary,
- no entry or return sequence is in progress.

On acceptance the mask takes the winning level and the previous mask is kept aside. A one-cycle take pulse then appears together with the winning source index as the vector number. A busy output covers the entry latency. A return pulse starts the return latency, and at its end the kept mask is restored.

Top module: `irq_accept_unit`

## Requirements
- R1: `pending` is high exactly when some source has its cause flag set, its enable flag set and a level other than 7.
- R2: A cause flag is set by `evt_set` and cleared only by `sw_cause_clr`. When both arrive in the same cycle, the set wins. Acceptance leaves the cause flag set.
- R3: An enable flag is set by `sw_en_set` and cleared by `sw_en_clr`. When both arrive in the same cycle, the clear wins.
- R4: Levels are 3-bit, and 0 is the most urgent. The winner is the requesting source with the numerically lowest level. A tie goes to the lower source index, and that index is driven on `vec_num` with the take pulse.
- R5: A request is taken only if its level is strictly lower than `cur_mask`. An equal or higher level is not taken.
- R6: While `gie` is 0, no request is taken, and `pending` stays high.
- R7: A request is taken only in a cycle with `insn_done` high.
- R8: An acceptance in cycle t gives, in cycle t+1, `take_irq` high for exactly one cycle, `vec_num` set to the winner and `cur_mask` set to the winner's level.
- R9: `busy` is high for exactly 24+6·WAIT_N cycles after an acceptance. No acceptance occurs while `busy` is high.
- R10: A `ret_pulse` while idle raises `busy` for exactly 15+6·WAIT_N cycles. When it falls, `cur_mask` holds the value it had before the last acceptance. A `ret_pulse` while busy is ignored.
- R11: `mask_wr` and `gie_wr` load `cur_mask` and `gie` in the next cycle. An acceptance in the same cycle as `mask_wr` wins over it.
- R12: After reset, all cause and enable flags are 0, `cur_mask` is 7, and `gie`, `busy` and `take_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set | input | NSRC | Hardware events that set the cause flags |
| sw_cause_clr | input | NSRC | Software clear of the cause flags |
| sw_en_set | input | NSRC | Software set of the enable flags |
| sw_en_clr | input | NSRC | Software clear of the enable flags |
| src_level | input | 3·NSRC | Level of each source, source i at bits [3i+2:3i] |
| mask_wr | input | 1 | Direct write strobe for the level mask |
| mask_wdata | input | 3 | Level mask write value |
| gie_wr | input | 1 | Direct write strobe for the global enable |
| gie_wdata | input | 1 | Global enable write value |
| insn_done | input | 1 | Instruction boundary reached |
| ret_pulse | input | 1 | Return-from-interrupt request |
| cause_q | output | NSRC | Cause flags |
| en_q | output | NSRC | Enable flags |
| pending | output | 1 | At least one request present |
| take_irq | output | 1 | One-cycle take-interrupt pulse |
| vec_num | output | log2(NSRC) | Index of the taken source |
| cur_mask | output | 3 | Current level mask |
| gie | output | 1 | Global interrupt enable |
| busy | output | 1 | Entry or return latency in progress |

## Verification
Two pairs of functions can meet in one cycle. A hardware event and a software clear can hit the same cause flag. A software mask write can coincide with an acceptance that also writes the mask. The bench drives both inputs of each pair in the same cycle. It then judges the cause flag against the rule that the set wins, and the mask against the rule that the acceptance level wins. Random rounds of levels, causes and enables are added and compared with a bench model of the arbitration.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int LVLW = 3;
  typedef logic [LVLW-1:0] lvl_t;
  localparam lvl_t LVL_OFF   = 3'd7;
  localparam lvl_t MASK_OPEN = 3'd7;
  localparam int LAT_ENTRY_BASE = 24;
  localparam int LAT_RET_BASE   = 15;
  localparam int LAT_PER_ACCESS = 6;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_set,
  input  logic [NSRC-1:0] cause_clr,
  input  logic [NSRC-1:0] en_set,
  input  logic [NSRC-1:0] en_clr,
  output logic [NSRC-1:0] cause_q,
  output logic [NSRC-1:0] en_q
);
  logic [NSRC-1:0] cause_d;
  logic [NSRC-1:0] en_d;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_comb begin
      cause_d[g] = cause_q[g];
      if (cause_clr[g]) cause_d[g] = 1'b0;
      if (evt_set[g])   cause_d[g] = 1'b1;   // event has precedence
      en_d[g] = en_q[g];
      if (en_set[g]) en_d[g] = 1'b1;
      if (en_clr[g]) en_d[g] = 1'b0;         // clear has precedence
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cause_q[g] <= 1'b0;
        en_q[g]    <= 1'b0;
      end else begin
        cause_q[g] <= cause_d[g];
        en_q[g]    <= en_d[g];
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_accept_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]      req,
  input  logic [NSRC*LVLW-1:0] lvl_flat,
  output logic                 any_req,
  output logic [IDXW-1:0]      win_idx,
  output lvl_t                 win_lvl
);
  always_comb begin
    any_req = 1'b0;
    win_idx = '0;
    win_lvl = LVL_OFF;
    for (int i = 0; i < NSRC; i++) begin
      // strict compare keeps the lower index on equal levels
      if (req[i] && (!any_req || (lvl_flat[i*LVLW +: LVLW] < win_lvl))) begin
        any_req = 1'b1;
        win_idx = IDXW'(i);
        win_lvl = lvl_flat[i*LVLW +: LVLW];
      end
    end
  end
endmodule

// File: rtl/irq_accept_ctl.sv
module irq_accept_ctl
  import irq_accept_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int WAIT_N = 1,
  localparam int IDXW  = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int ENTRY_LAT = LAT_ENTRY_BASE + LAT_PER_ACCESS * WAIT_N,
  localparam int RET_LAT   = LAT_RET_BASE + LAT_PER_ACCESS * WAIT_N,
  localparam int CNTW      = $clog2(ENTRY_LAT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any_req,
  input  logic [IDXW-1:0] win_idx,
  input  lvl_t            win_lvl,
  input  logic            insn_done,
  input  logic            ret_pulse,
  input  logic            mask_wr,
  input  lvl_t            mask_wdata,
  input  logic            gie_wr,
  input  logic            gie_wdata,
  output logic            take_irq,
  output logic [IDXW-1:0] vec_num,
  output lvl_t            cur_mask,
  output logic            gie,
  output logic            busy
);
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            ret_mode_q, ret_mode_d;
  lvl_t            saved_q, saved_d, mask_d;
  logic            gie_d, take_d;
  logic [IDXW-1:0] vec_d;
  logic            lvl_ok, accept, ret_start, restore;

  assign busy      = (cnt_q != '0);
  assign lvl_ok    = any_req && (win_lvl < cur_mask);
  assign accept    = lvl_ok && gie && insn_done && !busy && !ret_pulse;
  assign ret_start = ret_pulse && !busy;
  assign restore   = ret_mode_q && (cnt_q == CNTW'(1));

  always_comb begin
    cnt_d      = busy ? cnt_q - CNTW'(1) : cnt_q;
    ret_mode_d = restore ? 1'b0 : ret_mode_q;
    saved_d    = saved_q;
    mask_d     = mask_wr ? mask_wdata : cur_mask;
    gie_d      = gie_wr ? gie_wdata : gie;
    take_d     = 1'b0;
    vec_d      = vec_num;
    if (restore) mask_d = saved_q;
    if (accept) begin
      take_d  = 1'b1;
      vec_d   = win_idx;
      saved_d = cur_mask;
      mask_d  = win_lvl;
      cnt_d   = CNTW'(ENTRY_LAT);
    end else if (ret_start) begin
      cnt_d      = CNTW'(RET_LAT);
      ret_mode_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      ret_mode_q <= 1'b0;
      saved_q    <= MASK_OPEN;
      cur_mask   <= MASK_OPEN;
      gie        <= 1'b0;
      take_irq   <= 1'b0;
      vec_num    <= '0;
    end else begin
      cnt_q      <= cnt_d;
      ret_mode_q <= ret_mode_d;
      saved_q    <= saved_d;
      cur_mask   <= mask_d;
      gie        <= gie_d;
      take_irq   <= take_d;
      vec_num    <= vec_d;
    end
  end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int WAIT_N = 1,
  localparam int IDXW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      evt_set,
  input  logic [NSRC-1:0]      sw_cause_clr,
  input  logic [NSRC-1:0]      sw_en_set,
  input  logic [NSRC-1:0]      sw_en_clr,
  input  logic [NSRC*LVLW-1:0] src_level,
  input  logic                 mask_wr,
  input  logic [LVLW-1:0]      mask_wdata,
  input  logic                 gie_wr,
  input  logic                 gie_wdata,
  input  logic                 insn_done,
  input  logic                 ret_pulse,
  output logic [NSRC-1:0]      cause_q,
  output logic [NSRC-1:0]      en_q,
  output logic                 pending,
  output logic                 take_irq,
  output logic [IDXW-1:0]      vec_num,
  output logic [LVLW-1:0]      cur_mask,
  output logic                 gie,
  output logic                 busy
);
  logic [NSRC-1:0] req;
  logic [IDXW-1:0] win_idx;
  lvl_t            win_lvl;

  irq_src_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .cause_clr(sw_cause_clr),
    .en_set(sw_en_set), .en_clr(sw_en_clr), .cause_q(cause_q), .en_q(en_q)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_req
    assign req[g] = cause_q[g] && en_q[g] && (src_level[g*LVLW +: LVLW] != LVL_OFF);
  end

  irq_arbiter #(.NSRC(NSRC)) u_arb (
    .req(req), .lvl_flat(src_level), .any_req(pending),
    .win_idx(win_idx), .win_lvl(win_lvl)
  );

  irq_accept_ctl #(.NSRC(NSRC), .WAIT_N(WAIT_N)) u_ctl (
    .clk(clk), .rst_n(rst_n), .any_req(pending), .win_idx(win_idx),
    .win_lvl(win_lvl), .insn_done(insn_done), .ret_pulse(ret_pulse),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .gie_wr(gie_wr),
    .gie_wdata(gie_wdata), .take_irq(take_irq), .vec_num(vec_num),
    .cur_mask(cur_mask), .gie(gie), .busy(busy)
  );
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt_set,
  input logic [NSRC-1:0] sw_cause_clr,
  input logic [NSRC-1:0] cause_q,
  input logic            insn_done,
  input logic            take_irq,
  input logic [2:0]      cur_mask,
  input logic            gie,
  input logic            busy
);
  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> !take_irq);                                    // R8
  AST_TAKE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> busy);                                         // R9
  AST_TAKE_NOT_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> !$past(busy));                                 // R9
  AST_TAKE_LOWERS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (cur_mask < $past(cur_mask)));                 // R5
  AST_TAKE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(gie));                                   // R6
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(insn_done));                             // R7
  AST_CAUSE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & $past((cause_q & ~sw_cause_clr) | evt_set))
              == $past((cause_q & ~sw_cause_clr) | evt_set)));  // R2
endmodule

bind irq_accept_unit irq_accept_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .sw_cause_clr(sw_cause_clr),
  .cause_q(cause_q), .insn_done(insn_done), .take_irq(take_irq),
  .cur_mask(cur_mask), .gie(gie), .busy(busy)
);

// File: tb/test_irq_accept_unit.sv
module test_irq_accept_unit;
  localparam int NSRC = 8;
  localparam int WAIT_N = 1;
  localparam int ENTRY = 24 + 6 * WAIT_N;
  localparam int RETL  = 15 + 6 * WAIT_N;

  logic clk, rst_n;
  logic [NSRC-1:0] evt_set, sw_cause_clr, sw_en_set, sw_en_clr;
  logic [NSRC*3-1:0] src_level;
  logic mask_wr, gie_wr, gie_wdata, insn_done, ret_pulse;
  logic [2:0] mask_wdata;
  logic [NSRC-1:0] cause_q, en_q;
  logic pending, take_irq, gie, busy;
  logic [2:0] vec_num, cur_mask;

  int checks = 0;
  int errors = 0;

  irq_accept_unit #(.NSRC(NSRC), .WAIT_N(WAIT_N)) i_irq_accept_unit (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    evt_set = '0; sw_cause_clr = '0; sw_en_set = '0; sw_en_clr = '0;
    mask_wr = 1'b0; gie_wr = 1'b0; ret_pulse = 1'b0; insn_done = 1'b0;
  endtask

  task automatic set_lvl(input int src, input int lvl);
    src_level[src*3 +: 3] = 3'(lvl);
  endtask

  function automatic int model_win(input logic [NSRC-1:0] c, input logic [NSRC-1:0] e,
                                   input logic [NSRC*3-1:0] l);
    int best = -1;
    int bl = 8;
    for (int i = 0; i < NSRC; i++)
      if (c[i] && e[i] && l[i*3 +: 3] != 3'd7 && int'(l[i*3 +: 3]) < bl) begin
        best = i;
        bl = int'(l[i*3 +: 3]);
      end
    return best;
  endfunction

  // count the busy cycles seen from now on, ending when busy falls
  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      step();
    end
  endtask

  task automatic clean();
    int n;
    busy_len(n);
    sw_cause_clr = '1; sw_en_clr = '1; mask_wr = 1'b1; mask_wdata = 3'd7;
    step();
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int w;
    logic [NSRC-1:0] rc, re;
    void'($urandom(32'd12345));
    rst_n = 1'b0;
    evt_set = '0; sw_cause_clr = '0; sw_en_set = '0; sw_en_clr = '0;
    mask_wr = 1'b0; mask_wdata = '0; gie_wr = 1'b0; gie_wdata = 1'b0;
    insn_done = 1'b0; ret_pulse = 1'b0;
    for (int i = 0; i < NSRC; i++) set_lvl(i, 5);
    repeat (3) @(negedge clk);
    chk("R12 cause", int'(cause_q), 0);
    chk("R12 en", int'(en_q), 0);
    chk("R12 mask", int'(cur_mask), 7);
    chk("R12 gie", int'(gie), 0);
    chk("R12 busy", int'(busy), 0);
    chk("R12 take", int'(take_irq), 0);
    rst_n = 1'b1;
    step();

    // R1 / R2 / R3 request formation
    evt_set[2] = 1'b1; step();
    chk("R2 event sets cause", int'(cause_q), 32'h4);
    chk("R1 no enable no request", int'(pending), 0);
    sw_en_set[2] = 1'b1; step();
    chk("R1 request present", int'(pending), 1);
    set_lvl(2, 7); #1;
    chk("R1 level 7 never requests", int'(pending), 0);
    set_lvl(2, 2);
    evt_set[5] = 1'b1; sw_cause_clr[5] = 1'b1; step();
    chk("R2 set beats clear", int'(cause_q[5]), 1);
    sw_cause_clr[5] = 1'b1; step();
    chk("R2 software clear", int'(cause_q[5]), 0);
    sw_en_set[6] = 1'b1; sw_en_clr[6] = 1'b1; step();
    chk("R3 clear beats set", int'(en_q[6]), 0);

    // R6: gie clear holds the request
    insn_done = 1'b1; step();
    chk("R6 no take with gie clear", int'(take_irq), 0);
    chk("R6 still pending", int'(pending), 1);
    gie_wr = 1'b1; gie_wdata = 1'b1; mask_wr = 1'b1; mask_wdata = 3'd2; step();
    chk("R11 gie written", int'(gie), 1);
    chk("R11 mask written", int'(cur_mask), 2);
    insn_done = 1'b1; step();
    chk("R5 equal level refused", int'(take_irq), 0);
    mask_wr = 1'b1; mask_wdata = 3'd3; step();
    step();
    chk("R7 no take without boundary", int'(take_irq), 0);
    insn_done = 1'b1; step();
    chk("R8 take pulse", int'(take_irq), 1);
    chk("R8 vector", int'(vec_num), 2);
    chk("R8 mask loaded", int'(cur_mask), 2);
    chk("R2 acceptance keeps cause", int'(cause_q[2]), 1);
    // R9: more urgent request and boundary held during busy
    evt_set[0] = 1'b1; sw_en_set[0] = 1'b1; set_lvl(0, 0);
    step();
    chk("R8 pulse one cycle", int'(take_irq), 0);
    n = 2;
    while (busy && n < 100) begin
      if (take_irq) chk("R9 no take while busy", 1, 0);
      insn_done = 1'b1;
      if (n == 10) ret_pulse = 1'b1;  // R10 ignored while busy
      step();
      if (busy) n++;
    end
    chk("R9 entry busy length", n, ENTRY);
    chk("R10 return ignored while busy", int'(busy), 0);
    // leave the urgent source out, return to mask 3
    sw_cause_clr[0] = 1'b1; step();
    sw_cause_clr[2] = 1'b1; ret_pulse = 1'b1; step();
    chk("R10 mask held during return", int'(cur_mask), 2);
    busy_len(n);
    chk("R10 return busy length", n, RETL);
    chk("R10 mask restored", int'(cur_mask), 3);

    // R4 ties and R11 collision
    clean();
    set_lvl(1, 2); set_lvl(4, 2); set_lvl(6, 4);
    evt_set = 8'h52; sw_en_set = 8'h52; step();
    insn_done = 1'b1; mask_wr = 1'b1; mask_wdata = 3'd6; step();
    chk("R4 tie to lower index", int'(vec_num), 1);
    chk("R11 acceptance beats mask write", int'(cur_mask), 2);
    clean();
    set_lvl(6, 0);
    evt_set = 8'h52; sw_en_set = 8'h52; step();
    insn_done = 1'b1; step();
    chk("R4 most urgent wins", int'(vec_num), 6);

    // random rounds against the model
    for (int k = 0; k < 30; k++) begin
      clean();
      for (int i = 0; i < NSRC; i++) set_lvl(i, int'($urandom % 8));
      rc = NSRC'($urandom); re = NSRC'($urandom);
      evt_set = rc; sw_en_set = re; step();
      w = model_win(rc, re, src_level);
      chk("R1 random pending", int'(pending), (w >= 0) ? 1 : 0);
      insn_done = 1'b1; step();
      chk("R8 random take", int'(take_irq), (w >= 0) ? 1 : 0);
      if (w >= 0) begin
        chk("R4 random vector", int'(vec_num), w);
        chk("R8 random mask", int'(cur_mask), int'(src_level[w*3 +: 3]));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule